// File: doc/BRIEF.md
# Dual-Channel Serial SAR Converter Capture Sequencer

This block runs two 12-bit serial successive-approximation converters side by side. One digitises the inverter output voltage and the other the load current. Both share one chip-select and one serial clock, which runs at half the system clock. Each sampling period has two phases. First comes an acquisition phase with the serial clock parked high and chip-select released. Its length is a runtime count of system clock cycles, and it may be far shorter than the time the input would need to settle to half an LSB. Then comes a conversion window of 14 serial clock periods with chip-select asserted. During that window both data lines are shifted in at the same moments, so every voltage code pairs with a current code taken at the same instant.

When the capture enable is high, periods follow one another directly. The period is 28 + n system cycles. At 100 MHz with n = 5 that is 33 cycles, about 3.03 MSPS. A calibration sweep can change n between periods in single-cycle steps, from one cycle up to the counter limit. The new value is read only at the start of each acquisition phase. Each completed pair appears on the code outputs together with a one-cycle valid strobe.

Top module: `dual_sar_capture`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, conv_cs_n is 1, ser_clk is 1, pair_valid is 0 and both code outputs are 0. Asserting rst_n mid-frame forces conv_cs_n and ser_clk high at once.
- R2: Once started, an acquisition phase keeps conv_cs_n and ser_clk high for exactly n system cycles. The phase begins on the cycle after capture_en is seen high in idle, or directly after a conversion window. n is the value of acq_cycles sampled when the phase begins.
- R3: An acq_cycles value of 0 is treated as 1, giving a one-cycle acquisition phase.
- R4: A conversion window holds conv_cs_n low for exactly 28 consecutive cycles. Number the window cycles 0 to 27. ser_clk is high in even-numbered cycles and low in odd-numbered cycles, which gives 13 low-to-high transitions inside the window and a 14th as the window ends.
- R5: Both data lines are sampled at the end of window cycles 1, 3, …, 23, which is just before each rising serial clock edge, MSB first. Bit 11 is taken at cycle 1 and bit k at cycle 2·(11−k)+1. The line values during the last two serial periods do not affect the codes.
- R6: pair_valid is high for exactly one cycle: the first cycle after each window, when conv_cs_n returns high. volt_code and curr_code take the new pair in that cycle and hold it at all other times.
- R7: With capture_en held high, successive pair_valid pulses are 28 + n cycles apart.
- R8: A change to acq_cycles during a period has no effect on that period's acquisition length. It applies from the next acquisition phase.
- R9: capture_en is sampled only in idle and in the last window cycle. When it is low there, the block finishes the window, delivers the pair and then stays idle with conv_cs_n and ser_clk high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_en | input | 1 | Keeps sampling periods running while high |
| acq_cycles | input | 10 | Acquisition length n in system cycles (0 acts as 1) |
| volt_sdo | input | 1 | Serial data from the voltage converter |
| curr_sdo | input | 1 | Serial data from the current converter |
| conv_cs_n | output | 1 | Shared chip-select, low during the conversion window |
| ser_clk | output | 1 | Shared serial clock, parked high outside the window |
| pair_valid | output | 1 | One-cycle strobe marking a new code pair |
| volt_code | output | 12 | Last voltage code |
| curr_code | output | 12 | Last current code |

## Verification
The assertions assume that the data lines change only after a rising serial clock edge and are stable across the system edge that samples them. They also assume that reset is asynchronous but released away from a clock edge. The bench's converter model moves its data line only after each rising ser_clk edge and during the dummy periods drives ones that must not reach the codes. The bench changes capture_en and acq_cycles only on falling system-clock edges. This includes changes in the middle of a period, so the block's own sampling points decide when they apply.

// File: rtl/sar_cap_pkg.sv
`timescale 1ns/1ps
package sar_cap_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_CONV = 2'd2
  } phase_e;
endpackage

// File: rtl/sar_frame_seq.sv
`timescale 1ns/1ps
module sar_frame_seq
  import sar_cap_pkg::*;
#(
  parameter int ACQ_W      = 10,
  parameter int DATA_W     = 12,
  parameter int SCK_CYCLES = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [ACQ_W-1:0] acq_len_i,
  output logic             cs_n_o,
  output logic             sck_o,
  output logic             shift_en_o,
  output logic             frame_done_o
);
  localparam int CONV_LEN = 2 * SCK_CYCLES;
  localparam int CONV_W   = $clog2(CONV_LEN);
  localparam int CNT_W    = (ACQ_W > CONV_W) ? ACQ_W : CONV_W;

  phase_e             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [ACQ_W-1:0]   nlat_q, nlat_d;
  logic               cs_n_q, cs_n_d;
  logic               sck_q, sck_d;
  logic [ACQ_W-1:0]   acq_clamped;
  logic [CNT_W-1:0]   nlat_ext;
  logic               acq_last;
  logic               conv_last;

  // Acquisition length is clamped to at least one cycle
  assign acq_clamped = (acq_len_i == '0) ? ACQ_W'(1) : acq_len_i;
  assign nlat_ext    = CNT_W'(nlat_q);
  assign acq_last    = (cnt_q == (nlat_ext - CNT_W'(1)));
  assign conv_last   = (cnt_q == CNT_W'(CONV_LEN - 1));

  // Data is taken on odd window cycles, ahead of each rising serial edge
  assign shift_en_o   = (phase_q == PH_CONV) && cnt_q[0] &&
                        ((cnt_q >> 1) < CNT_W'(DATA_W));
  assign frame_done_o = (phase_q == PH_CONV) && conv_last;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    nlat_d  = nlat_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (run_i) begin
          phase_d = PH_ACQ;
          cnt_d   = '0;
          nlat_d  = acq_clamped;
        end
      end
      PH_ACQ: begin
        if (acq_last) begin
          phase_d = PH_CONV;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_CONV: begin
        if (conv_last) begin
          cnt_d = '0;
          if (run_i) begin
            phase_d = PH_ACQ;
            nlat_d  = acq_clamped;
          end else begin
            phase_d = PH_IDLE;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  // Pins come straight from flops, decoded from the next state
  always_comb begin
    cs_n_d = (phase_d != PH_CONV);
    sck_d  = !((phase_d == PH_CONV) && cnt_d[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      nlat_q  <= '0;
      cs_n_q  <= 1'b1;
      sck_q   <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      nlat_q  <= nlat_d;
      cs_n_q  <= cs_n_d;
      sck_q   <= sck_d;
    end
  end

  assign cs_n_o = cs_n_q;
  assign sck_o  = sck_q;
endmodule

// File: rtl/sar_shift_chan.sv
`timescale 1ns/1ps
module sar_shift_chan #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdo_i,
  input  logic              shift_en_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] code_o
);
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [DATA_W-1:0] code_q, code_d;

  always_comb begin
    shreg_d = shreg_q;
    if (shift_en_i) shreg_d = {shreg_q[DATA_W-2:0], sdo_i};
    code_d = code_q;
    if (load_i) code_d = shreg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      code_q  <= '0;
    end else begin
      shreg_q <= shreg_d;
      code_q  <= code_d;
    end
  end

  assign code_o = code_q;
endmodule

// File: rtl/dual_sar_capture.sv
`timescale 1ns/1ps
module dual_sar_capture #(
  parameter int ACQ_W      = 10,
  parameter int DATA_W     = 12,
  parameter int SCK_CYCLES = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_en,
  input  logic [ACQ_W-1:0]  acq_cycles,
  input  logic              volt_sdo,
  input  logic              curr_sdo,
  output logic              conv_cs_n,
  output logic              ser_clk,
  output logic              pair_valid,
  output logic [DATA_W-1:0] volt_code,
  output logic [DATA_W-1:0] curr_code
);
  localparam int NUM_CH = 2;

  logic                    shift_en;
  logic                    frame_done;
  logic                    valid_q;
  logic [NUM_CH-1:0]       sdo_vec;
  logic [DATA_W-1:0]       code_arr [NUM_CH];

  assign sdo_vec = {curr_sdo, volt_sdo};

  sar_frame_seq #(
    .ACQ_W      (ACQ_W),
    .DATA_W     (DATA_W),
    .SCK_CYCLES (SCK_CYCLES)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (capture_en),
    .acq_len_i    (acq_cycles),
    .cs_n_o       (conv_cs_n),
    .sck_o        (ser_clk),
    .shift_en_o   (shift_en),
    .frame_done_o (frame_done)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    sar_shift_chan #(.DATA_W(DATA_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .sdo_i      (sdo_vec[g]),
      .shift_en_i (shift_en),
      .load_i     (frame_done),
      .code_o     (code_arr[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= frame_done;
  end

  assign pair_valid = valid_q;
  assign volt_code  = code_arr[0];
  assign curr_code  = code_arr[1];
endmodule

// File: rtl/sar_capture_chk.sv
`timescale 1ns/1ps
module sar_capture_chk #(
  parameter int DATA_W     = 12,
  parameter int SCK_CYCLES = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_cs_n,
  input logic              ser_clk,
  input logic              pair_valid,
  input logic [DATA_W-1:0] volt_code,
  input logic [DATA_W-1:0] curr_code
);
  localparam int CONV_LEN = 2 * SCK_CYCLES;
  localparam int LOW_W    = $clog2(CONV_LEN) + 1;

  logic [LOW_W-1:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_q <= '0;
    else if (!conv_cs_n) low_q <= low_q + 1'b1;
    else                low_q <= '0;
  end

  AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    conv_cs_n |-> ser_clk); // R2
  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_cs_n && (low_q != '0)) |-> (low_q == LOW_W'(CONV_LEN))); // R4
  AST_WINDOW_OPEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_cs_n && $past(conv_cs_n)) |-> ser_clk); // R4
  AST_SCK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_cs_n && $past(!conv_cs_n)) |-> (ser_clk != $past(ser_clk))); // R4
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid); // R6
  AST_VALID_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_cs_n) |-> pair_valid); // R6
  AST_VALID_ONLY_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> $rose(conv_cs_n)); // R6
  AST_CODES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> ($stable(volt_code) && $stable(curr_code))); // R6
endmodule

bind dual_sar_capture sar_capture_chk #(
  .DATA_W     (DATA_W),
  .SCK_CYCLES (SCK_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_cs_n  (conv_cs_n),
  .ser_clk    (ser_clk),
  .pair_valid (pair_valid),
  .volt_code  (volt_code),
  .curr_code  (curr_code)
);

// File: tb/dual_sar_capture_bench.sv
`timescale 1ns/1ps
module dual_sar_capture_bench;
  logic        clk;
  logic        rst_n;
  logic        capture_en;
  logic [9:0]  acq_cycles;
  logic        volt_sdo;
  logic        curr_sdo;
  logic        conv_cs_n;
  logic        ser_clk;
  logic        pair_valid;
  logic [11:0] volt_code;
  logic [11:0] curr_code;

  int n_checks = 0;
  int n_fail   = 0;

  logic [11:0] dev_v;
  logic [11:0] dev_i;
  logic [3:0]  rise_cnt;

  dual_sar_capture u_dual_sar_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .acq_cycles (acq_cycles),
    .volt_sdo   (volt_sdo),
    .curr_sdo   (curr_sdo),
    .conv_cs_n  (conv_cs_n),
    .ser_clk    (ser_clk),
    .pair_valid (pair_valid),
    .volt_code  (volt_code),
    .curr_code  (curr_code)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Converter model: new bit after each rising serial edge, ones in dummy periods
  always @(posedge ser_clk or posedge conv_cs_n) begin
    if (conv_cs_n) rise_cnt <= 4'd0;
    else           rise_cnt <= rise_cnt + 4'd1;
  end
  assign volt_sdo = (rise_cnt < 4'd12) ? dev_v[4'd11 - rise_cnt] : 1'b1;
  assign curr_sdo = (rise_cnt < 4'd12) ? dev_i[4'd11 - rise_cnt] : 1'b1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {n, voltage code, current code}
  localparam logic [33:0] VEC [6] = '{
    {10'd5,  12'hA5C, 12'h3F1},
    {10'd0,  12'h000, 12'hFFF},
    {10'd1,  12'h800, 12'h001},
    {10'd12, 12'h5A3, 12'hC3C},
    {10'd50, 12'h7FE, 12'hC01},
    {10'd2,  12'hFFF, 12'h000}
  };

  task automatic one_frame(input logic [9:0] n, input logic [11:0] v, input logic [11:0] c);
    int k, l, rises, exp_n;
    bit sck_bad, prev;
    exp_n = (n == 0) ? 1 : int'(n);
    dev_v = v; dev_i = c; acq_cycles = n;
    @(negedge clk) capture_en = 1'b1;
    k = 0; sck_bad = 1'b0;
    @(negedge clk);
    while (conv_cs_n) begin
      k++;
      if (!ser_clk) sck_bad = 1'b1;
      @(negedge clk);
    end
    check(k == exp_n, (n == 0) ? "R3 clamped acquisition length" : "R2 acquisition length", k, exp_n);
    check(!sck_bad, "R2 serial clock parked high", sck_bad, 0);
    capture_en = 1'b0;
    l = 0; rises = 0; prev = ser_clk;
    while (!conv_cs_n) begin
      l++;
      if (ser_clk && !prev) rises++;
      prev = ser_clk;
      @(negedge clk);
    end
    check(l == 28, "R4 window length", l, 28);
    check(rises == 13, "R4 rising edges in window", rises, 13);
    check(pair_valid, "R6 valid after window", pair_valid, 1);
    check(volt_code == v, "R5 voltage code", volt_code, v);
    check(curr_code == c, "R5 current code", curr_code, c);
    @(negedge clk);
    check(!pair_valid, "R6 valid one cycle", pair_valid, 0);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      check(conv_cs_n && ser_clk && !pair_valid, "R9 idle after enable low",
            {conv_cs_n, ser_clk, pair_valid}, 3'b110);
    end
    check(volt_code == v && curr_code == c, "R6 codes held", volt_code, v);
  endtask

  task automatic valid_gap(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!pair_valid);
  endtask

  initial begin
    int gap;
    rst_n = 1'b0; capture_en = 1'b0; acq_cycles = 10'd5;
    dev_v = '0; dev_i = '0;
    repeat (3) @(negedge clk);
    check(conv_cs_n && ser_clk && !pair_valid, "R1 reset pins", {conv_cs_n, ser_clk, pair_valid}, 3'b110);
    check(volt_code == 0 && curr_code == 0, "R1 reset codes", volt_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(conv_cs_n && ser_clk && !pair_valid, "R1 after release", {conv_cs_n, ser_clk, pair_valid}, 3'b110);

    for (int e = 0; e < 6; e++) begin
      one_frame(VEC[e][33:24], VEC[e][23:12], VEC[e][11:0]);
    end

    // R7 and R8: continuous periods, acq_cycles changed mid-period
    dev_v = 12'h1E7; dev_i = 12'h9C2; acq_cycles = 10'd5;
    @(negedge clk) capture_en = 1'b1;
    valid_gap(gap);
    valid_gap(gap);
    check(gap == 33, "R7 period for n=5", gap, 33);
    check(volt_code == 12'h1E7 && curr_code == 12'h9C2, "R5 code in continuous run", volt_code, 12'h1E7);
    acq_cycles = 10'd20;
    valid_gap(gap);
    check(gap == 33, "R8 change not applied mid-period", gap, 33);
    valid_gap(gap);
    check(gap == 48, "R7 period for n=20", gap, 48);
    acq_cycles = 10'd0;
    valid_gap(gap);
    valid_gap(gap);
    check(gap == 29, "R3 period for n=0", gap, 29);

    // R1: reset in the middle of a conversion window
    while (conv_cs_n) @(negedge clk);
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check(conv_cs_n && ser_clk, "R1 async reset mid-window", {conv_cs_n, ser_clk}, 2'b11);
    capture_en = 1'b0;
    @(negedge clk);
    check(volt_code == 0 && curr_code == 0 && !pair_valid, "R1 codes cleared", volt_code, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(conv_cs_n && !pair_valid, "R9 idle after reset with enable low", conv_cs_n, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule